// File: doc/BRIEF.md
# Integer Execute Unit with Overflow Trap

This block is the integer execution stage of a three-operand RISC core. Each transaction carries an operation code, two register operands (`rs`, `rt`), a 16-bit immediate and a 5-bit shift field. The block returns a 32-bit result, a trap flag for signed overflow, and a write-enable that tells the core whether the destination register may be updated. The operations are add and subtract in both a trapping and a non-trapping form, and add-immediate in both forms. There are also AND, OR, XOR and NOR on registers, and AND, OR and XOR with an immediate. The shifts are left-logical, right-logical and right-arithmetic, by an immediate amount or by a register amount.

Whether an add can trap depends only on which operation was chosen. The operands are not tagged signed or unsigned: both forms compute the same two's-complement sum. Arithmetic immediates are sign-extended. Logical immediates are zero-extended. A register shift amount takes only the low five bits of `rt`.

The compute path is combinational and feeds one output register. The register sits behind a valid/ready pair on each side. An input transaction is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stalls the producer with no bubble. While `out_valid` is high and `out_ready` is low, every output stays unchanged.

Top module: `alu_core`

## Requirements
- R1: ADD (code 0), ADDU (1), SUB (2) and SUBU (3) return rs+rt or rs-rt, wrapped to 32 bits.
- R2: ADD, SUB and ADDI (4) assert the trap flag exactly when the signed two's-complement result overflows. ADDU, SUBU and ADDIU (5) never assert it.
- R3: ADDI and ADDIU add rs to the 16-bit immediate after sign-extending it, so 0x8000 adds -32768.
- R4: ANDI (10), ORI (11) and XORI (12) combine rs with the immediate after zero-extending it.
- R5: AND (6), OR (7), XOR (8) and NOR (9) combine rs with rt bitwise. NOR returns ~(rs|rt).
- R6: SLLV (16), SRLV (17) and SRAV (18) shift rs by rt[4:0]. The upper bits of rt are ignored.
- R7: SLL (13), SRL (14) and SRA (15) shift rs by the 5-bit shift field. Right-logical shifts fill with zeros. Right-arithmetic shifts copy the sign bit. Left shifts fill with zeros.
- R8: Bitwise and shift operations never assert the trap flag.
- R9: When the trap flag is set, the result still carries the wrapped 32-bit value and write-enable is low. Any other legal operation raises write-enable.
- R10: Codes 19 to 31 return result 0, no trap and write-enable low.
- R11: `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, result, trap and write-enable hold steady and `out_valid` stays high.
- R12: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Block can take an input transaction |
| in_op | input | 5 | Operation code |
| in_rs | input | 32 | First register operand |
| in_rt | input | 32 | Second register operand |
| in_imm | input | 16 | Immediate field |
| in_shamt | input | 5 | Immediate shift amount |
| out_valid | output | 1 | Result register holds a transaction |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Computed value, wrapped on overflow |
| out_trap | output | 1 | Signed overflow on a trapping operation |
| out_wren | output | 1 | Destination register may be written |

## Verification
The bench builds the block with its defaults: a 32-bit datapath and a 16-bit immediate. These widths bring the signed-overflow boundaries 0x7FFFFFFF and 0x80000000 within reach, as well as the immediate sign boundary between 0x7FFF and 0x8000. Operands are drawn from those corner values, from 0 and 0xFFFFFFFF, and at random. This exercises overflow in both directions, rt words whose upper bits would spoil a shift count that used them, and sign fill on arithmetic shifts. Random consumer stalls exercise the hold rule on the output register and the ready path through it.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [4:0] OP_ADD   = 5'd0;
  localparam logic [4:0] OP_ADDU  = 5'd1;
  localparam logic [4:0] OP_SUB   = 5'd2;
  localparam logic [4:0] OP_SUBU  = 5'd3;
  localparam logic [4:0] OP_ADDI  = 5'd4;
  localparam logic [4:0] OP_ADDIU = 5'd5;
  localparam logic [4:0] OP_AND   = 5'd6;
  localparam logic [4:0] OP_OR    = 5'd7;
  localparam logic [4:0] OP_XOR   = 5'd8;
  localparam logic [4:0] OP_NOR   = 5'd9;
  localparam logic [4:0] OP_ANDI  = 5'd10;
  localparam logic [4:0] OP_ORI   = 5'd11;
  localparam logic [4:0] OP_XORI  = 5'd12;
  localparam logic [4:0] OP_SLL   = 5'd13;
  localparam logic [4:0] OP_SRL   = 5'd14;
  localparam logic [4:0] OP_SRA   = 5'd15;
  localparam logic [4:0] OP_SLLV  = 5'd16;
  localparam logic [4:0] OP_SRLV  = 5'd17;
  localparam logic [4:0] OP_SRAV  = 5'd18;

  typedef enum logic [1:0] {
    UNIT_ARITH,
    UNIT_LOGIC,
    UNIT_SHIFT,
    UNIT_NONE
  } unit_e;

  typedef enum logic [1:0] {
    BSRC_RT,
    BSRC_SEXT,
    BSRC_ZEXT
  } bsrc_e;

  typedef enum logic [1:0] {
    LFN_AND,
    LFN_OR,
    LFN_XOR,
    LFN_NOR
  } lfn_e;

  typedef enum logic [1:0] {
    SHD_LL,
    SHD_RL,
    SHD_RA
  } shd_e;

  typedef struct packed {
    logic  legal;
    unit_e unit;
    bsrc_e bsrc;
    logic  sub;
    logic  trap_en;
    lfn_e  lfn;
    shd_e  shd;
    logic  shvar;
  } ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [4:0] op,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl         = '0;
    ctrl.unit    = UNIT_NONE;
    ctrl.bsrc    = BSRC_RT;
    ctrl.lfn     = LFN_AND;
    ctrl.shd     = SHD_LL;
    ctrl.legal   = 1'b1;
    case (op)
      OP_ADD:   begin ctrl.unit = UNIT_ARITH; ctrl.trap_en = 1'b1; end
      OP_ADDU:  begin ctrl.unit = UNIT_ARITH; end
      OP_SUB:   begin ctrl.unit = UNIT_ARITH; ctrl.sub = 1'b1; ctrl.trap_en = 1'b1; end
      OP_SUBU:  begin ctrl.unit = UNIT_ARITH; ctrl.sub = 1'b1; end
      OP_ADDI:  begin ctrl.unit = UNIT_ARITH; ctrl.bsrc = BSRC_SEXT; ctrl.trap_en = 1'b1; end
      OP_ADDIU: begin ctrl.unit = UNIT_ARITH; ctrl.bsrc = BSRC_SEXT; end
      OP_AND:   begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LFN_AND; end
      OP_OR:    begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LFN_OR;  end
      OP_XOR:   begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LFN_XOR; end
      OP_NOR:   begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LFN_NOR; end
      OP_ANDI:  begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LFN_AND; ctrl.bsrc = BSRC_ZEXT; end
      OP_ORI:   begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LFN_OR;  ctrl.bsrc = BSRC_ZEXT; end
      OP_XORI:  begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LFN_XOR; ctrl.bsrc = BSRC_ZEXT; end
      OP_SLL:   begin ctrl.unit = UNIT_SHIFT; ctrl.shd = SHD_LL; end
      OP_SRL:   begin ctrl.unit = UNIT_SHIFT; ctrl.shd = SHD_RL; end
      OP_SRA:   begin ctrl.unit = UNIT_SHIFT; ctrl.shd = SHD_RA; end
      OP_SLLV:  begin ctrl.unit = UNIT_SHIFT; ctrl.shd = SHD_LL; ctrl.shvar = 1'b1; end
      OP_SRLV:  begin ctrl.unit = UNIT_SHIFT; ctrl.shd = SHD_RL; ctrl.shvar = 1'b1; end
      OP_SRAV:  begin ctrl.unit = UNIT_SHIFT; ctrl.shd = SHD_RA; ctrl.shvar = 1'b1; end
      default:  begin ctrl.legal = 1'b0; end
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  output logic [XLEN-1:0] sum,
  output logic            ovf
);

  logic [XLEN-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + {{(XLEN-1){1'b0}}, sub};
    // same-sign inputs with a differently signed result means overflow;
    // for subtract the inverted operand turns this into the differing-sign rule
    ovf   = (a[XLEN-1] == b_eff[XLEN-1]) && (sum[XLEN-1] != a[XLEN-1]);
  end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  lfn_e            fn,
  output logic [XLEN-1:0] y
);

  always_comb begin
    case (fn)
      LFN_AND: y = a & b;
      LFN_OR:  y = a | b;
      LFN_XOR: y = a ^ b;
      default: y = ~(a | b);
    endcase
  end

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
  import alu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] a,
  input  logic [SHW-1:0]  amt,
  input  shd_e            dir,
  output logic [XLEN-1:0] y
);

  always_comb begin
    case (dir)
      SHD_LL:  y = a << amt;
      SHD_RL:  y = a >> amt;
      default: y = $unsigned($signed(a) >>> amt);
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [4:0]      in_op,
  input  logic [XLEN-1:0] in_rs,
  input  logic [XLEN-1:0] in_rt,
  input  logic [IMMW-1:0] in_imm,
  input  logic [SHW-1:0]  in_shamt,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_trap,
  output logic            out_wren
);

  localparam int EXTW = XLEN - IMMW;

  ctrl_t           ctrl;
  logic [XLEN-1:0] imm_sext, imm_zext, opb;
  logic [XLEN-1:0] sum, lres, sres;
  logic            ovf;
  logic [SHW-1:0]  shamt;
  logic [XLEN-1:0] nxt_result;
  logic            nxt_trap, nxt_wren;
  logic            accept;

  alu_decode u_dec (.op(in_op), .ctrl(ctrl));

  always_comb begin
    imm_sext = {{EXTW{in_imm[IMMW-1]}}, in_imm};
    imm_zext = {{EXTW{1'b0}}, in_imm};
    case (ctrl.bsrc)
      BSRC_SEXT: opb = imm_sext;
      BSRC_ZEXT: opb = imm_zext;
      default:   opb = in_rt;
    endcase
    shamt = ctrl.shvar ? in_rt[SHW-1:0] : in_shamt;
  end

  alu_addsub #(.XLEN(XLEN)) u_add (
    .a(in_rs), .b(opb), .sub(ctrl.sub), .sum(sum), .ovf(ovf)
  );

  alu_logic_unit #(.XLEN(XLEN)) u_log (
    .a(in_rs), .b(opb), .fn(ctrl.lfn), .y(lres)
  );

  alu_shift_unit #(.XLEN(XLEN)) u_shf (
    .a(in_rs), .amt(shamt), .dir(ctrl.shd), .y(sres)
  );

  always_comb begin
    case (ctrl.unit)
      UNIT_ARITH: nxt_result = sum;
      UNIT_LOGIC: nxt_result = lres;
      UNIT_SHIFT: nxt_result = sres;
      default:    nxt_result = '0;
    endcase
    nxt_trap = ctrl.legal && (ctrl.unit == UNIT_ARITH) && ctrl.trap_en && ovf;
    nxt_wren = ctrl.legal && !nxt_trap;
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_trap   <= 1'b0;
      out_wren   <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= nxt_result;
      out_trap   <= nxt_trap;
      out_wren   <= nxt_wren;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [4:0]      in_op,
  input logic [XLEN-1:0] in_rs,
  input logic [XLEN-1:0] in_rt,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result,
  input logic            out_trap,
  input logic            out_wren
);

  logic acc;
  logic op_quiet, op_nontrap_add, op_nor;

  assign acc            = in_valid && in_ready;
  assign op_quiet       = (in_op >= OP_AND) && (in_op <= OP_SRAV);
  assign op_nontrap_add = (in_op == OP_ADDU) || (in_op == OP_SUBU) || (in_op == OP_ADDIU);
  assign op_nor         = (in_op == OP_NOR);

  assert_unsigned_no_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_nontrap_add |=> !out_trap);

  assert_nor_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_nor |=> out_result == ~($past(in_rs) | $past(in_rt)));

  assert_quiet_no_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_quiet |=> !out_trap);

  assert_trap_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trap |-> !out_wren);

  assert_hold_output_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_trap) && $stable(out_wren));

  assert_ready_when_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

bind alu_core alu_core_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_rs(in_rs), .in_rt(in_rt), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_trap(out_trap),
  .out_wren(out_wren)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [31:0] in_rs = '0;
  logic [31:0] in_rt = '0;
  logic [15:0] in_imm = '0;
  logic [4:0]  in_shamt = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_trap;
  logic        out_wren;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        trap;
    logic        wren;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  alu_core dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rs(in_rs), .in_rt(in_rt), .in_imm(in_imm),
    .in_shamt(in_shamt), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_trap(out_trap), .out_wren(out_wren)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pick_word();
    int sel = $urandom_range(0, 9);
    case (sel)
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0000;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [15:0] pick_imm();
    int sel = $urandom_range(0, 5);
    case (sel)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  // reference behaviour per requirement
  function automatic exp_t model(input int op, input logic [31:0] rs, input logic [31:0] rt,
                                 input logic [15:0] imm, input logic [4:0] sh);
    exp_t e;
    longint s;
    logic [31:0] se, ze;
    bit may_trap;
    se = 32'($signed(imm));
    ze = {16'h0, imm};
    e.trap = 1'b0;
    e.wren = 1'b1;
    may_trap = (op == 0) || (op == 2) || (op == 4);
    s = 0;
    case (op)
      0, 1: begin s = longint'($signed(rs)) + longint'($signed(rt)); e.res = rs + rt; e.tag = "R1"; end
      2, 3: begin s = longint'($signed(rs)) - longint'($signed(rt)); e.res = rs - rt; e.tag = "R1"; end
      4, 5: begin s = longint'($signed(rs)) + longint'($signed(se)); e.res = rs + se; e.tag = "R3"; end
      6:  begin e.res = rs & rt;    e.tag = "R5"; end
      7:  begin e.res = rs | rt;    e.tag = "R5"; end
      8:  begin e.res = rs ^ rt;    e.tag = "R5"; end
      9:  begin e.res = ~(rs | rt); e.tag = "R5"; end
      10: begin e.res = rs & ze;    e.tag = "R4"; end
      11: begin e.res = rs | ze;    e.tag = "R4"; end
      12: begin e.res = rs ^ ze;    e.tag = "R4"; end
      13: begin e.res = rs << sh;   e.tag = "R7"; end
      14: begin e.res = rs >> sh;   e.tag = "R7"; end
      15: begin e.res = $signed(rs) >>> sh; e.tag = "R7"; end
      16: begin e.res = rs << rt[4:0]; e.tag = "R6"; end
      17: begin e.res = rs >> rt[4:0]; e.tag = "R6"; end
      18: begin e.res = $signed(rs) >>> rt[4:0]; e.tag = "R6"; end
      default: begin e.res = 32'h0; e.wren = 1'b0; e.tag = "R10"; end
    endcase
    if (may_trap && (s > 64'sd2147483647 || s < -64'sd2147483648)) begin
      e.trap = 1'b1;
      e.wren = 1'b0;
    end
    return e;
  endfunction

  logic        prev_stall = 1'b0;
  logic [31:0] prev_res;
  logic        prev_trap, prev_wren;

  task automatic observe();
    exp_t e;
    check("R11 ready rule", {31'h0, in_ready}, {31'h0, (!out_valid || out_ready)});
    if (prev_stall) begin
      check("R11 hold valid", {31'h0, out_valid}, 32'h1);
      check("R11 hold result", out_result, prev_res);
      check("R11 hold flags", {30'h0, out_trap, out_wren}, {30'h0, prev_trap, prev_wren});
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected output", 32'h1, 32'h0);
      end else begin
        e = exp_q.pop_front();
        check({e.tag, " result"}, out_result, e.res);
        check((e.tag == "R1" || e.tag == "R3") ? "R2 trap" : (e.tag == "R10" ? "R10 trap" : "R8 trap"),
              {31'h0, out_trap}, {31'h0, e.trap});
        check("R9 write enable", {31'h0, out_wren}, {31'h0, e.wren});
      end
    end
    if (in_valid && in_ready)
      exp_q.push_back(model(int'(in_op), in_rs, in_rt, in_imm, in_shamt));
    prev_stall = out_valid && !out_ready;
    prev_res   = out_result;
    prev_trap  = out_trap;
    prev_wren  = out_wren;
  endtask

  task automatic send(input int op, input logic [31:0] rs, input logic [31:0] rt,
                      input logic [15:0] imm, input logic [4:0] sh);
    @(negedge clk);
    in_valid = 1'b1; in_op = 5'(op); in_rs = rs; in_rt = rt; in_imm = imm; in_shamt = sh;
    out_ready = 1'b1;
    #1 observe();
    while (!(in_valid && in_ready)) begin
      @(negedge clk);
      #1 observe();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R12 reset valid", {31'h0, out_valid}, 32'h0);
    check("R12 reset ready", {31'h0, in_ready}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    send(0,  32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0);        // R2 positive overflow
    send(1,  32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0);        // R2 non-trapping form
    send(2,  32'h8000_0000, 32'h1, 16'h0, 5'd0);        // R2 negative overflow
    send(3,  32'h8000_0000, 32'h1, 16'h0, 5'd0);
    send(4,  32'h8000_0000, 32'h0, 16'h8000, 5'd0);     // R3 -32768 traps
    send(5,  32'h0000_0010, 32'h0, 16'h8000, 5'd0);     // R3 sign extension
    send(4,  32'h7FFF_FFFF, 32'h0, 16'h7FFF, 5'd0);
    send(10, 32'hFFFF_FFFF, 32'h0, 16'h8000, 5'd0);     // R4 zero extension
    send(11, 32'h0,         32'h0, 16'hFFFF, 5'd0);
    send(9,  32'h0,         32'h0, 16'h0, 5'd0);        // R5 NOR of zeros
    send(16, 32'h1,         32'hFFFF_FFE4, 16'h0, 5'd0); // R6 uses low 5 bits only
    send(18, 32'h8000_0000, 32'h0000_0023, 16'h0, 5'd0);
    send(15, 32'h8000_0000, 32'h0, 16'h0, 5'd31);       // R7 sign fill
    send(14, 32'h8000_0000, 32'h0, 16'h0, 5'd31);       // R7 zero fill
    send(25, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd3); // R10

    // random traffic with back-pressure
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!(in_valid && !in_ready)) begin
        in_valid = ($urandom_range(0, 4) != 0);
        in_op    = 5'($urandom_range(0, 21));
        in_rs    = pick_word();
        in_rt    = pick_word();
        in_imm   = pick_imm();
        in_shamt = 5'($urandom_range(0, 31));
      end
      out_ready = ($urandom_range(0, 3) != 0);
      #1 observe();
    end

    // drain
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b1;
      #1 observe();
    end
    check("R11 queue drained", exp_q.size(), 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule